// File: doc/BRIEF.md
# Clocked Serial Receiver with Overrun Lock

This block takes in 8-bit frames from a clock-synchronous serial line and hands each finished frame to a host through a small register port. Bits are captured on the rising transfer-clock edge, least significant bit first. The transfer clock can come from two places. As clock master, the block divides its own system clock by an even, programmable factor and drives the clock line; that line sits high while reception is off. As clock slave, it follows a clock applied from outside. That clock passes through a two-stage synchronizer, and its rising edges are found in the system clock domain.

When a frame finishes, the byte goes into the data register and a full flag rises. If the interrupt enable is on, the interrupt line goes high. Reading the data register drops the full flag. If a frame finishes while the previous byte is still unread, that frame is thrown away and an overrun flag sets. From then on the receiver takes nothing in until software writes the overrun flag back to 0. Turning the receive enable off drops any half-received frame, but the stored byte and the flags are left as they are.

Top module: `sync_serial_rx`

## Requirements
- R1: After reset, the control register reads 0, status reads 0, data reads 0, the divider reads 1, `sck_out` is 1 and `irq` is 0.
- R2: While receive enable (control bit 0) is 0, clock edges on the line are ignored and the status full bit stays 0.
- R3: With master mode (control bit 2) and receive enable both set, `sck_out` toggles every N system cycles, where N is the divider register (a value of 0 acts as 1). This gives a period of 2N cycles. `sck_out` returns high within one cycle of reception stopping.
- R4: The bit on `sdi` is captured at each rising transfer-clock edge. The first bit captured becomes data bit 0. After the eighth capture the byte is stored in the data register (address 2) and status bit 0 (full) is set.
- R5: `irq` is high exactly while status full is 1 and control bit 1 (interrupt enable) is 1.
- R6: A host read of address 2 returns the stored byte, and the full bit is 0 from the next cycle on.
- R7: If full is 1 when a frame's eighth capture happens, status bit 1 (overrun) sets and the data register keeps its old byte.
- R8: While overrun is 1, no frame is received, even after the data register has been read. Once overrun is cleared, reception resumes.
- R9: Clearing receive enable in the middle of a frame throws away the bits collected so far. The next frame after re-enabling is received whole, and the data register and flags do not change when enable is cleared.
- R10: If the host reads address 2 in the same cycle that a frame completes, the read returns the old byte. The new byte is then stored, full stays 1, and overrun stays 0.
- R11: A write to address 1 clears overrun only when wdata bit 1 is 0. Writing 1 there has no effect, and status bit 0 cannot be written.
- R12: Register addresses: 0 control (bit 0 enable, bit 1 interrupt enable, bit 2 master), 1 status, 2 data (read only), 3 divider half-period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (side effect on data register only) |
| host_addr | input | 2 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr`, same cycle |
| sck_in | input | 1 | Transfer clock from outside (slave mode) |
| sck_out | output | 1 | Generated transfer clock (master mode), idles high |
| sdi | input | 1 | Serial data in |
| irq | output | 1 | Receive interrupt, level |

## Verification
Two events can land in the same cycle: a host read of the data register and the completion of a new frame. Which of the two wins decides whether the frame is kept or an overrun is reported. The bench works this out from the known synchronizer latency in slave mode. It counts the system edges after the eighth rising `sck_in` and puts its read strobe exactly in the cycle where the frame completes. It then checks three things: the read returned the old byte, the new byte was stored with full still set, and overrun stayed clear. A separate case, with no read, checks that the same completion does set overrun and leaves the old byte in place.

// File: rtl/ssrx_pkg.sv
package ssrx_pkg;
    localparam int FRAME_W = 8;
    localparam int REG_W   = 8;
    localparam int ADDR_W  = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 2'd0,
        A_STAT = 2'd1,
        A_DATA = 2'd2,
        A_DIV  = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/ssrx_clkgen.sv
module ssrx_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             sck,
    output logic             rise
);
    typedef struct packed {
        logic             sck;
        logic [DIV_W-1:0] cnt;
    } cg_t;

    cg_t s_d, s_q;
    logic [DIV_W:0] cnt_nx;

    always_comb begin
        s_d    = s_q;
        rise   = 1'b0;
        cnt_nx = {1'b0, s_q.cnt} + 1'b1;
        if (!run) begin
            s_d.sck = 1'b1;
            s_d.cnt = '0;
        end else if (cnt_nx >= {1'b0, half}) begin
            s_d.sck = ~s_q.sck;
            s_d.cnt = '0;
            rise    = ~s_q.sck;
        end else begin
            s_d.cnt = cnt_nx[DIV_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{sck: 1'b1, cnt: '0};
        else        s_q <= s_d;
    end

    assign sck = s_q.sck;

    // R3
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> sck);

    // R3
    rise_only_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (sck && !$past(sck)));
endmodule

// File: rtl/ssrx_edge_sync.sv
module ssrx_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_raw,
    input  logic sdi_raw,
    output logic rise,
    output logic sdi_sync
);
    typedef struct packed {
        logic [2:0] ck;
        logic [1:0] dt;
    } sy_t;

    sy_t s_d, s_q;

    always_comb begin
        s_d.ck = {s_q.ck[1:0], sck_raw};
        s_d.dt = {s_q.dt[0], sdi_raw};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{ck: 3'b111, dt: 2'b00};
        else        s_q <= s_d;
    end

    assign rise     = s_q.ck[1] & ~s_q.ck[2];
    assign sdi_sync = s_q.dt[1];

    // R4
    single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/ssrx_shifter.sv
module ssrx_shifter #(
    parameter int W = ssrx_pkg::FRAME_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active,
    input  logic         rise,
    input  logic         bit_in,
    output logic         done,
    output logic [W-1:0] frame
);
    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     sr;
    } sh_t;

    sh_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        frame = {bit_in, s_q.sr[W-1:1]};
        done  = active && rise && (s_q.cnt == LAST);
        if (!active) begin
            s_d.cnt = '0;
        end else if (rise) begin
            s_d.sr  = frame;
            s_d.cnt = done ? '0 : s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R9
    abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (s_q.cnt == '0));
endmodule

// File: rtl/sync_serial_rx.sv
module sync_serial_rx
    import ssrx_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [REG_W-1:0]  host_wdata,
    output logic [REG_W-1:0]  host_rdata,
    input  logic              sck_in,
    output logic              sck_out,
    input  logic              sdi,
    output logic              irq
);
    typedef struct packed {
        logic               en;
        logic               ie;
        logic               master;
        logic [DIV_W-1:0]   half;
        logic [FRAME_W-1:0] data;
        logic               full;
        logic               ovr;
    } hr_t;

    hr_t r_d, r_q;

    logic active, m_rise, s_rise, s_sdi, rise, bit_in;
    logic done, rd_hit;
    logic [FRAME_W-1:0] frame;

    assign active = r_q.en & ~r_q.ovr;

    ssrx_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(active & r_q.master),
        .half(r_q.half), .sck(sck_out), .rise(m_rise)
    );

    ssrx_edge_sync u_sync (
        .clk(clk), .rst_n(rst_n), .sck_raw(sck_in), .sdi_raw(sdi),
        .rise(s_rise), .sdi_sync(s_sdi)
    );

    assign rise   = r_q.master ? m_rise : s_rise;
    assign bit_in = r_q.master ? sdi : s_sdi;

    ssrx_shifter #(.W(FRAME_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .active(active), .rise(rise),
        .bit_in(bit_in), .done(done), .frame(frame)
    );

    always_comb begin
        r_d    = r_q;
        rd_hit = host_rd && (host_addr == A_DATA);
        if (host_wr) begin
            case (host_addr)
                A_CTRL: begin
                    r_d.en     = host_wdata[0];
                    r_d.ie     = host_wdata[1];
                    r_d.master = host_wdata[2];
                end
                A_STAT:  if (!host_wdata[1]) r_d.ovr = 1'b0;
                A_DIV:   r_d.half = host_wdata[DIV_W-1:0];
                default: ;
            endcase
        end
        if (rd_hit) r_d.full = 1'b0;
        if (done) begin
            if (r_q.full && !rd_hit) begin
                r_d.ovr = 1'b1;
            end else begin
                r_d.data = frame;
                r_d.full = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.half <= DIV_W'(1);
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (host_addr)
            A_CTRL:  host_rdata = REG_W'({r_q.master, r_q.ie, r_q.en});
            A_STAT:  host_rdata = REG_W'({r_q.ovr, r_q.full});
            A_DATA:  host_rdata = REG_W'(r_q.data);
            default: host_rdata = REG_W'(r_q.half);
        endcase
    end

    assign irq = r_q.full & r_q.ie;

    // R7
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && r_q.full && !rd_hit) |=> (r_q.ovr && $stable(r_q.data)));

    // R8
    locked_no_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ovr |-> !done);

    // R4
    full_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.full) |-> $past(done));

    // R6
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.full) |-> $past(rd_hit));
endmodule

// File: tb/sync_serial_rx_test.sv
`timescale 1ns/1ps
module sync_serial_rx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [1:0] host_addr = 2'd0;
    logic [7:0] host_wdata = 8'd0;
    logic [7:0] host_rdata;
    logic       sck_in = 1'b1, sck_out, sdi = 1'b0, irq;

    int checks = 0, fails = 0;
    logic [7:0] v, coll_val;

    sync_serial_rx uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .sck_in(sck_in), .sck_out(sck_out), .sdi(sdi), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        @(posedge clk); #1;
        host_addr = a; #1;
        d = host_rdata;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(posedge clk); #1;
        host_rd = 1'b1; host_addr = a; #1;
        d = host_rdata;
        @(posedge clk); #1;
        host_rd = 1'b0;
    endtask

    task automatic send(input logic [7:0] b, input int nbits, input bit rd_at_end);
        for (int i = 0; i < nbits; i++) begin
            @(posedge clk); #1;
            sck_in = 1'b0; sdi = b[i];
            repeat (3) @(posedge clk);
            #1 sck_in = 1'b1;
            if (i == 7 && rd_at_end) begin
                repeat (2) @(posedge clk);
                #1 host_rd = 1'b1; host_addr = 2'd2; #1;
                coll_val = host_rdata;
                @(posedge clk); #1 host_rd = 1'b0;
            end else begin
                repeat (3) @(posedge clk);
            end
        end
        repeat (3) @(posedge clk);
    endtask

    task automatic t_reset();
        peek(2'd0, v); chk("R1", "ctrl", v, 0);
        peek(2'd1, v); chk("R1", "status", v, 0);
        peek(2'd2, v); chk("R1", "data", v, 0);
        peek(2'd3, v); chk("R12", "divider", v, 1);
        chk("R1", "sck_out", sck_out, 1);
        chk("R1", "irq", irq, 0);
    endtask

    task automatic t_disabled();
        send(8'h5A, 8, 0);
        peek(2'd1, v); chk("R2", "status while disabled", v, 0);
    endtask

    task automatic t_slave_rx();
        wr(2'd0, 8'h03);
        send(8'h3C, 8, 0);
        peek(2'd1, v); chk("R4", "full set", v, 1);
        chk("R5", "irq with ie", irq, 1);
        rd(2'd2, v);   chk("R4", "data lsb first", v, 8'h3C);
        peek(2'd1, v); chk("R6", "full cleared by read", v, 0);
        chk("R5", "irq after read", irq, 0);
        wr(2'd0, 8'h01);
        send(8'h81, 8, 0);
        peek(2'd1, v); chk("R4", "full second frame", v, 1);
        chk("R5", "irq masked", irq, 0);
    endtask

    task automatic t_overrun();
        send(8'h55, 8, 0);
        peek(2'd1, v); chk("R7", "overrun set", v, 3);
        peek(2'd2, v); chk("R7", "data kept", v, 8'h81);
        rd(2'd2, v);
        send(8'h77, 8, 0);
        peek(2'd1, v); chk("R8", "no rx while locked", v, 2);
        wr(2'd1, 8'h02);
        peek(2'd1, v); chk("R11", "write 1 keeps overrun", v, 2);
        wr(2'd1, 8'h01);
        peek(2'd1, v); chk("R11", "clear overrun, full not written", v, 0);
        send(8'h11, 8, 0);
        peek(2'd2, v); chk("R8", "rx resumes", v, 8'h11);
        rd(2'd2, v);
    endtask

    task automatic t_abort();
        wr(2'd0, 8'h03);
        send(8'h11, 8, 0);
        send(8'hFF, 4, 0);
        wr(2'd0, 8'h00);
        peek(2'd1, v); chk("R9", "flags kept on disable", v, 1);
        peek(2'd2, v); chk("R9", "data kept on disable", v, 8'h11);
        rd(2'd2, v);
        wr(2'd0, 8'h01);
        send(8'hC3, 8, 0);
        peek(2'd2, v); chk("R9", "fresh frame after abort", v, 8'hC3);
    endtask

    task automatic t_collision();
        send(8'h9A, 8, 1);
        chk("R10", "read returns old byte", coll_val, 8'hC3);
        peek(2'd1, v); chk("R10", "full kept, no overrun", v, 1);
        peek(2'd2, v); chk("R10", "new byte stored", v, 8'h9A);
        rd(2'd2, v);
    endtask

    task automatic t_master();
        realtime t0, t1;
        logic [7:0] b = 8'hA5;
        wr(2'd0, 8'h00);
        wr(2'd3, 8'h03);
        wr(2'd0, 8'h05);
        @(posedge sck_out); t0 = $realtime;
        @(posedge sck_out); t1 = $realtime;
        chk("R3", "master period cycles", int'((t1 - t0) / 20.0), 6);
        wr(2'd0, 8'h04);
        @(posedge clk); #2;
        chk("R3", "idle high", sck_out, 1);
        repeat (4) @(posedge clk);
        #2 chk("R3", "stays high", sck_out, 1);
        wr(2'd0, 8'h05);
        for (int i = 0; i < 8; i++) begin
            @(negedge sck_out); #1 sdi = b[i];
            @(posedge sck_out);
        end
        repeat (2) @(posedge clk);
        wr(2'd0, 8'h04);
        peek(2'd2, v); chk("R4", "master frame data", v, 8'hA5);
        peek(2'd1, v); chk("R4", "master full", v, 1);
    endtask

    initial begin
        #4_000_000;
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_disabled();
        t_slave_rx();
        t_overrun();
        t_abort();
        t_collision();
        t_master();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule